// File: doc/BRIEF.md
# Search Coprocessor Read Responder

This block is the device side of a search coprocessor's read path. The coprocessor shares a 68-bit bidirectional data bus with a host. The host issues a read instruction by raising a command-valid strobe, placing the read opcode on the low command bits and putting the target device ID and the location address on the data bus. If the device ID matches, the responder runs a fixed bus-turnaround sequence. It leaves two quiet cycles while the host lets go of the bus, then drives the bus and an acknowledge line, returns one or more data words, and releases every line to high impedance.

A single read returns one word from the address carried in the instruction. A burst read returns consecutive words. It takes its start address and its beat count from an internal burst register, which the host loads in advance. The address in that register moves forward by one on every beat, and it keeps its new value after the burst ends. In a burst, a second line, end-of-transfer, flags the last beat. Each tri-stated pin is modelled as a value plus an output enable. Storage is a behavioural word array that is filled through a plain write port.

The read path has no back-pressure. Once the host has issued a read, the response timing is fixed, and the host must sample each word in the cycle in which acknowledge is high. The block accepts a new instruction only when it is idle.

Top module: `srr_top`

## Requirements
- R1: An instruction is a read only when `cmd_valid` is 1 and `cmd[1:0]` is 2'b00. With `cmd_valid` low, or with any other opcode, all output enables stay 0.
- R2: The responder answers only when `dq_in[25:21]` equals `dev_id`. The value 5'b11111 also selects the device, but only when `last_dev` is 1.
- R3: For a single read (`cmd[2]`=0) issued in cycle 1, the outputs are as follows:
  - Cycles 2 and 3 are quiet.
  - Cycle 4 has `dq_oe`=1, `dq_out`=0, `ack_oe`=1 and `ack_out`=0.
  - Cycle 5 has `ack_out`=1 and `dq_out` = the word at address `dq_in[5:0]`.
  - Cycle 6 has `dq_oe`=0, `ack_oe`=1 and `ack_out`=0.
  - From cycle 7 every enable is 0.
- R4: During a single read, `eot_oe` stays 0.
- R5: A burst read (`cmd[2]`=1) of n beats lasts 4+2n cycles. Each beat is a pair of cycles, a lead cycle and then a data cycle. In the lead cycle the bus is driven to 0 and acknowledge is low. In the data cycle acknowledge is high and the bus carries the word. Beat k, counting from 0, returns the word at the burst start address + k, modulo 64.
- R6: In a burst, `eot_oe` follows `ack_oe`. `eot_out` is 1 only in the data cycle of the last beat. In the final cycle the bus is released and acknowledge and end-of-transfer are both driven low. After that, both lines are released.
- R7: A burst length field of 0 gives one beat.
- R8: After a burst of n beats, the burst register address has advanced by n, modulo 64. A following burst starts from that address.
- R9: An instruction that arrives while a read is in progress is ignored. The current read continues unchanged and no extra response follows it.
- R10: A load of the burst register (`bst_ld`) is applied only when the responder is idle and is ignored otherwise. `mem_we` writes `mem_wdata` into the word at `mem_waddr`.
- R11: While reset is held, all output enables, `ack_out` and `eot_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | This device's ID |
| last_dev | input | 1 | Marks this device as the one answering ID 11111 |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Opcode in [1:0]; [2] selects burst |
| dq_in | input | 68 | Bus value seen by the device |
| dq_out | output | 68 | Bus value driven by the device |
| dq_oe | output | 1 | Bus output enable |
| ack_out | output | 1 | Acknowledge level |
| ack_oe | output | 1 | Acknowledge output enable |
| eot_out | output | 1 | End-of-transfer level |
| eot_oe | output | 1 | End-of-transfer output enable |
| mem_we | input | 1 | Storage write strobe |
| mem_waddr | input | 6 | Storage write address |
| mem_wdata | input | 68 | Storage write data |
| bst_ld | input | 1 | Burst register load strobe |
| bst_addr_in | input | 6 | Burst start address to load |
| bst_len_in | input | 4 | Burst beat count to load |

## Verification
A sequencer stuck in the wrong state shows up at once, within one cycle, as an enable pattern that does not belong to any legal cycle of the read sequence. A beat counter that is off by one shows up at the end of a burst. End-of-transfer then rises on the wrong data cycle, or the final cycle comes early or late, and the 4+2n cycle count breaks. A burst address that is wrong or not kept shows up as wrong data in the first data cycle, either of the current burst or of the next one, which exposes a missing wrap or a lost increment. A busy check that lets a command through, or a register load taken while busy, shows up as an extra response or a shifted address within a few cycles of the read.

// File: rtl/srr_pkg.sv
package srr_pkg;
  // Opcode in the two low command bits that means "read".
  localparam logic [1:0] OP_READ = 2'b00;
  // Device-ID value that selects the device whose last-device bit is set.
  localparam logic [4:0] ID_LAST = 5'h1F;
  // Lowest bus bit of the device-ID field.
  localparam int ID_LSB = 21;
  localparam int ID_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP1,
    ST_GAP2,
    ST_LEAD,
    ST_DATA,
    ST_TAIL
  } srr_state_e;
endpackage

// File: rtl/srr_decode.sv
module srr_decode
  import srr_pkg::*;
(
  input  logic            cmd_valid,
  input  logic [2:0]      cmd,
  input  logic [ID_W-1:0] id_field,
  input  logic [ID_W-1:0] dev_id,
  input  logic            last_dev,
  output logic            hit,
  output logic            is_burst
);
  logic is_read;
  logic id_match;

  always_comb begin
    is_read  = cmd_valid && (cmd[1:0] == OP_READ);
    id_match = (id_field == dev_id) || ((id_field == ID_LAST) && last_dev);
    hit      = is_read && id_match;
    is_burst = cmd[2];
  end
endmodule

// File: rtl/srr_seq.sv
module srr_seq
  import srr_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             burst,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             beat_done,
  output logic             dq_oe,
  output logic             data_phase,
  output logic             ack_out,
  output logic             ack_oe,
  output logic             eot_out,
  output logic             eot_oe
);
  srr_state_e       state_q;
  logic             burst_q;
  logic [LEN_W-1:0] left_q;
  logic             last_beat;

  assign last_beat = (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_GAP1;
            burst_q <= burst;
            if (burst) left_q <= (len == '0) ? LEN_W'(1) : len;
            else       left_q <= LEN_W'(1);
          end
        end
        ST_GAP1: state_q <= ST_GAP2;
        ST_GAP2: state_q <= ST_LEAD;
        ST_LEAD: state_q <= ST_DATA;
        ST_DATA: begin
          left_q  <= left_q - LEN_W'(1);
          state_q <= last_beat ? ST_TAIL : ST_LEAD;
        end
        ST_TAIL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state_q != ST_IDLE);
    data_phase = (state_q == ST_DATA);
    beat_done  = data_phase;
    dq_oe      = (state_q == ST_LEAD) || (state_q == ST_DATA);
    ack_oe     = dq_oe || (state_q == ST_TAIL);
    ack_out    = data_phase;
    eot_oe     = burst_q && ack_oe;
    eot_out    = burst_q && data_phase && last_beat;
  end
endmodule

// File: rtl/srr_store.sv
module srr_store #(
  parameter int ADDR_W = 6,
  parameter int DQ_W   = 68,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DQ_W-1:0]   mem_wdata,
  input  logic              bst_ld,
  input  logic [ADDR_W-1:0] bst_addr_in,
  input  logic [LEN_W-1:0]  bst_len_in,
  input  logic              busy,
  input  logic              start,
  input  logic              start_burst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              beat_done,
  output logic [LEN_W-1:0]  bst_len,
  output logic [DQ_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DQ_W-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0] bst_addr_q;
  logic [LEN_W-1:0]  bst_len_q;
  logic [ADDR_W-1:0] sgl_addr_q;
  logic              burst_mode_q;
  logic [ADDR_W-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_addr_q   <= '0;
      bst_len_q    <= '0;
      sgl_addr_q   <= '0;
      burst_mode_q <= 1'b0;
    end else begin
      if (!busy) begin
        if (bst_ld) begin
          bst_addr_q <= bst_addr_in;
          bst_len_q  <= bst_len_in;
        end
        if (start) begin
          burst_mode_q <= start_burst;
          if (!start_burst) sgl_addr_q <= start_addr;
        end
      end else if (beat_done && burst_mode_q) begin
        bst_addr_q <= bst_addr_q + ADDR_W'(1);
      end
    end
  end

  assign rd_addr = burst_mode_q ? bst_addr_q : sgl_addr_q;
  assign rd_data = mem[rd_addr];
  assign bst_len = bst_len_q;
endmodule

// File: rtl/srr_top.sv
module srr_top
  import srr_pkg::*;
#(
  parameter int DQ_W   = 68,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              last_dev,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe,
  output logic              eot_out,
  output logic              eot_oe,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DQ_W-1:0]   mem_wdata,
  input  logic              bst_ld,
  input  logic [ADDR_W-1:0] bst_addr_in,
  input  logic [LEN_W-1:0]  bst_len_in
);
  logic             hit;
  logic             is_burst;
  logic             busy;
  logic             start;
  logic             beat_done;
  logic             data_phase;
  logic [LEN_W-1:0] bst_len;
  logic [DQ_W-1:0]  rd_data;

  srr_decode u_decode (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .id_field  (dq_in[ID_LSB +: ID_W]),
    .dev_id    (dev_id),
    .last_dev  (last_dev),
    .hit       (hit),
    .is_burst  (is_burst)
  );

  assign start = hit && !busy;

  srr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst      (is_burst),
    .len        (bst_len),
    .busy       (busy),
    .beat_done  (beat_done),
    .dq_oe      (dq_oe),
    .data_phase (data_phase),
    .ack_out    (ack_out),
    .ack_oe     (ack_oe),
    .eot_out    (eot_out),
    .eot_oe     (eot_oe)
  );

  srr_store #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .LEN_W(LEN_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .bst_ld      (bst_ld),
    .bst_addr_in (bst_addr_in),
    .bst_len_in  (bst_len_in),
    .busy        (busy),
    .start       (start),
    .start_burst (is_burst),
    .start_addr  (dq_in[ADDR_W-1:0]),
    .beat_done   (beat_done),
    .bst_len     (bst_len),
    .rd_data     (rd_data)
  );

  assign dq_out = data_phase ? rd_data : '0;
endmodule

// File: rtl/srr_checker.sv
module srr_checker (
  input logic clk,
  input logic rst_n,
  input logic dq_oe,
  input logic ack_out,
  input logic ack_oe,
  input logic eot_out,
  input logic eot_oe
);
  // R3
  bus_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe);
  // R3
  ack_high_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (dq_oe && ack_oe));
  // R5
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> (ack_oe && !ack_out));
  // R6
  eot_within_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_oe |-> ack_oe);
  // R6
  eot_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_out |-> (ack_out && eot_oe));
  // R6
  eot_then_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_out |=> (!dq_oe && ack_oe && !ack_out && eot_oe && !eot_out));
  // R3
  release_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> $past(!dq_oe && !ack_out));
endmodule

bind srr_top srr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dq_oe   (dq_oe),
  .ack_out (ack_out),
  .ack_oe  (ack_oe),
  .eot_out (eot_out),
  .eot_oe  (eot_oe)
);

// File: tb/tb_srr_top.sv
module tb_srr_top;
  localparam int DQ_W = 68;
  localparam int AW   = 6;
  localparam int LW   = 4;
  localparam int EXP_W = DQ_W + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] dev_id = 5'd9;
  logic last_dev = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic [DQ_W-1:0] dq_in = '0;
  logic [DQ_W-1:0] dq_out;
  logic dq_oe, ack_out, ack_oe, eot_out, eot_oe;
  logic mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [DQ_W-1:0] mem_wdata = '0;
  logic bst_ld = 1'b0;
  logic [AW-1:0] bst_addr_in = '0;
  logic [LW-1:0] bst_len_in = '0;

  srr_top dut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic mon_on = 1'b0;
  logic [EXP_W-1:0] exp_q[$];
  string tag_q[$];
  logic [DQ_W-1:0] ref_mem [64];
  logic [AW-1:0] m_addr = '0;
  logic [LW-1:0] m_len = '0;

  function automatic logic [DQ_W-1:0] word_of(int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h01010101 ^ 32'hC3A50F00;
    b = ~(32'(i) * 32'd7);
    return {4'h9, a, b};
  endfunction

  function automatic logic [EXP_W-1:0] item(logic oe, logic [DQ_W-1:0] d,
      logic aoe, logic a, logic eoe, logic e);
    return {oe, aoe, a, eoe, e, d};
  endfunction

  task automatic check(logic ok, string tag, logic [EXP_W-1:0] act, logic [EXP_W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, expv);
    end
  endtask

  task automatic push(logic [EXP_W-1:0] it, string tag);
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic push_idle(int n, string tag);
    for (int i = 0; i < n; i++) push('0, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      logic [EXP_W-1:0] e, act;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = '0;
        t = "R1 idle";
      end
      act = {dq_oe, ack_oe, ack_out, eot_oe, eot_out, dq_out};
      check(act === e, t, act, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0);
  endtask

  task automatic issue(logic v, logic [2:0] c, logic [4:0] id, logic [AW-1:0] a);
    @(negedge clk); #1;
    cmd_valid = v; cmd = c;
    dq_in = '0; dq_in[25:21] = id; dq_in[AW-1:0] = a;
  endtask

  task automatic release_cmd();
    @(negedge clk); #1;
    cmd_valid = 1'b0; cmd = 3'b000; dq_in = '0;
  endtask

  task automatic push_single(logic [AW-1:0] a, string tag);
    push_idle(2, tag);
    push(item(1, '0, 1, 0, 0, 0), tag);
    push(item(1, ref_mem[a], 1, 1, 0, 0), tag);
    push(item(0, '0, 1, 0, 0, 0), tag);
  endtask

  task automatic single_read(logic [4:0] id, logic [AW-1:0] a, logic resp, string tag);
    issue(1'b1, 3'b000, id, a);
    if (resp) push_single(a, tag); else push_idle(6, tag);
    release_cmd();
    drain();
  endtask

  task automatic push_burst(string tag);
    int n;
    n = (m_len == 0) ? 1 : int'(m_len);
    push_idle(2, tag);
    for (int k = 0; k < n; k++) begin
      push(item(1, '0, 1, 0, 1, 0), tag);
      push(item(1, ref_mem[m_addr + AW'(k)], 1, 1, 1, (k == n - 1)), tag);
    end
    push(item(0, '0, 1, 0, 1, 0), tag);
    m_addr = m_addr + AW'(n);
  endtask

  task automatic burst_read(string tag);
    issue(1'b1, 3'b100, dev_id, '0);
    push_burst(tag);
    release_cmd();
    drain();
  endtask

  task automatic load_burst(logic [AW-1:0] a, logic [LW-1:0] l);
    @(negedge clk); #1;
    bst_ld = 1'b1; bst_addr_in = a; bst_len_in = l;
    @(negedge clk); #1;
    bst_ld = 1'b0;
    m_addr = a; m_len = l;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({dq_oe, ack_oe, ack_out, eot_oe, eot_out} === 5'b0, "R11 reset",
          {dq_oe, ack_oe, ack_out, eot_oe, eot_out, dq_out}, '0);
    #1 rst_n = 1'b1;
    // R10: fill storage through the write port
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); #1;
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = word_of(i);
      ref_mem[i] = word_of(i);
    end
    @(negedge clk); #1 mem_we = 1'b0;
    mon_on = 1'b1;

    // R3 R4 R10: single reads at several addresses
    single_read(5'd9, 6'd0, 1'b1, "R3 single a0");
    single_read(5'd9, 6'd37, 1'b1, "R4 single a37");
    single_read(5'd9, 6'd63, 1'b1, "R10 single a63");
    // R1: not a read
    issue(1'b0, 3'b000, 5'd9, 6'd4); push_idle(6, "R1 no strobe"); release_cmd(); drain();
    issue(1'b1, 3'b001, 5'd9, 6'd4); push_idle(6, "R1 other opcode"); release_cmd(); drain();
    // R2: id selection
    single_read(5'd8, 6'd4, 1'b0, "R2 wrong id");
    single_read(5'h1F, 6'd4, 1'b0, "R2 all-ones not last");
    last_dev = 1'b1;
    single_read(5'h1F, 6'd12, 1'b1, "R2 all-ones last");
    last_dev = 1'b0;

    // R5 R6: burst of 3
    load_burst(6'd10, 4'd3);
    burst_read("R5 burst3");
    // R8: next burst continues at 13
    burst_read("R8 continue");
    // R7: zero length gives one beat
    load_burst(6'd20, 4'd0);
    burst_read("R7 len0");
    // R8: wrap at end of storage
    load_burst(6'd62, 4'd4);
    burst_read("R8 wrap");
    burst_read("R6 after wrap");

    // R9: command while busy ignored
    issue(1'b1, 3'b000, 5'd9, 6'd5);
    push_single(6'd5, "R9 busy read");
    push_idle(4, "R9 no extra");
    @(negedge clk); #1; cmd_valid = 1'b1; cmd = 3'b000; dq_in[AW-1:0] = 6'd40;
    @(negedge clk); #1; cmd = 3'b100;
    release_cmd();
    drain();

    // R10: burst register load during busy ignored
    load_burst(6'd30, 4'd2);
    issue(1'b1, 3'b100, dev_id, '0);
    push_burst("R10 ld busy");
    release_cmd();
    @(negedge clk); #1; bst_ld = 1'b1; bst_addr_in = 6'd50; bst_len_in = 4'd6;
    @(negedge clk); #1; bst_ld = 1'b0;
    drain();
    burst_read("R10 ld ignored");

    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule